// File: doc/BRIEF.md
# Test-Cycle Pin Drive and Capture Engine

This block runs one functional test cycle against a device under test with a parameterised number of pins (139 by default). Each pin carries four settings. The direction code says whether the pin is stimulated, observed or left floating. The drive bit is the stimulus value. The force-format code shapes the stimulus in time. The waveform-select bit ties the pin to one of two internal timing waveforms: a data waveform or a clock waveform. The clock waveform can be shifted in phase against the data waveform.

Settings are written into a staging bank at any time. A rising edge on the start request copies the staging bank into an active bank. The engine then opens the timing waveforms for exactly one waveform period. Stimulated pins change on the rising edge of their own waveform. Every observed pin is sampled on the falling edge of the data waveform. The engine then blocks the waveforms and holds a lockout period before it accepts another start. The capture vector and a one-cycle done pulse are the result. Comparison against expected values is left to the consumer.

All timing counts in system clock cycles. The start edge is accepted on clock edge 0, and run-cycle c is the cycle that follows edge c. The pin outputs are registered, so the effect of run-cycle c appears after edge c+1.

Top module: `tce_engine`

## Requirements
- R1: While reset is high and right after it, pin_drive, pin_oe, capture and done are all 0, and every pin is undriven.
- R2: The 2-bit direction code of a pin works as follows: 01 means the pin is stimulated (pin_oe=1), 10 means it is observed (pin_oe=0), and 00 or 11 means it is floating (pin_oe=0). Any pin whose pin_oe is 0 drives 0.
- R3: Format code 00 (non-return): a stimulated pin takes its drive bit at the rising edge of its waveform and holds it until that edge in a later run.
- R4: Format code 01 (return-low): a stimulated pin shows its drive bit while its waveform is high, and 0 at all other times, including idle and lockout.
- R5: Format code 10 (return-high): a stimulated pin shows its drive bit while its waveform is high, and 1 at all other times, including idle and lockout.
- R6: Format code 11 (inverted): a stimulated pin takes the complement of its drive bit at the rising edge of its waveform and holds it.
- R7: The data waveform is high in run-cycles 0 to PERIOD_CYC/2-1. The clock waveform rises at run-cycle phase*PERIOD_CYC/8, where phase is the 2-bit phase code 0..3, and stays high for PERIOD_CYC/2 cycles. A pin with select bit 0 follows the data waveform; a pin with select bit 1 follows the clock waveform.
- R8: In run-cycle PERIOD_CYC/2 (the data falling edge), every observed pin is captured from pin_in, whatever its waveform select. All other capture bits are 0. The capture vector then holds until the next capture.
- R9: done is high for exactly one cycle per run: the cycle in which the new capture vector first appears.
- R10: Writes to the staging bank during a run do not change that run. The run uses the settings that were staged when its start was accepted, and a later run uses the new settings.
- R11: A start is accepted only on a 0-to-1 change of start_req while the engine is idle. A request held high does not start a second run. Rises during a run or the lockout are ignored.
- R12: A run lasts PERIOD_CYC cycles and is followed by LOCK_CYC lockout cycles. During the lockout both waveforms are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_load | input | 1 | Writes all staging fields this cycle |
| stage_dir | input | 2*N_PINS | Direction code per pin, pin i at bits 2i+1:2i |
| stage_drive | input | N_PINS | Drive bit per pin |
| stage_fmt | input | 2*N_PINS | Force-format code per pin, pin i at bits 2i+1:2i |
| stage_wsel | input | N_PINS | Waveform select per pin (0 data, 1 clock) |
| stage_phase | input | 2 | Clock waveform phase code |
| start_req | input | 1 | Start request, edge-detected |
| pin_in | input | N_PINS | Values returned by the device pins |
| pin_drive | output | N_PINS | Stimulus value per pin |
| pin_oe | output | N_PINS | Output enable per pin |
| capture | output | N_PINS | Captured device outputs |
| done | output | 1 | One-cycle pulse when capture updates |

## Verification
The bench goes after the hold behaviour of the non-return and inverted formats when a pin tied to the clock waveform has not yet seen its rising edge in the current run. A design that reset those pins instead of holding them would show the wrong value in the first cycles of the run. Clock pins use all four phase codes, so an offset error moves a return-low or return-high pulse by whole eighths of the period. Staging writes are made in the middle of a run, which exposes a design that does not keep a separate active bank. Start requests are also made to rise during the run and during the lockout, and are held high afterwards: an engine that triggered on level, or that ignored the lockout, would produce a second done pulse. The device inputs change after the capture cycle, so a design that kept sampling them would alter the capture vector.

// File: rtl/tce_pkg.sv
package tce_pkg;

  typedef enum logic [1:0] {
    DIR_FLOAT = 2'b00,
    DIR_STIM  = 2'b01,
    DIR_OBS   = 2'b10,
    DIR_FLT2  = 2'b11
  } pin_dir_e;

  typedef enum logic [1:0] {
    FMT_HOLD = 2'b00,
    FMT_RLOW = 2'b01,
    FMT_RHI  = 2'b10,
    FMT_INV  = 2'b11
  } force_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_LOCK = 2'b10
  } run_state_e;

  // Next drive value of one pin given its settings and its waveform state.
  function automatic logic pin_next(input logic [1:0] dir, input logic [1:0] fmt,
                                    input logic bv, input logic lvl,
                                    input logic rise, input logic hold);
    logic r;
    if (dir != DIR_STIM) begin
      r = 1'b0;
    end else begin
      case (force_fmt_e'(fmt))
        FMT_HOLD: r = rise ? bv : hold;
        FMT_RLOW: r = lvl ? bv : 1'b0;
        FMT_RHI:  r = lvl ? bv : 1'b1;
        default:  r = rise ? ~bv : hold;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/tce_timing.sv
module tce_timing #(
  parameter int PERIOD_CYC = 128,
  parameter int LOCK_CYC   = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_req,
  input  logic       stage_load,
  input  logic [1:0] stage_phase,
  output logic       accept,
  output logic       running,
  output logic       data_lvl,
  output logic       clk_lvl,
  output logic       data_rise,
  output logic       clk_rise,
  output logic       data_fall
);
  import tce_pkg::*;

  localparam int HALF = PERIOD_CYC / 2;
  localparam int STEP = PERIOD_CYC / 8;
  localparam int CW   = $clog2(PERIOD_CYC);
  localparam int LW   = $clog2(LOCK_CYC);

  run_state_e    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] clk_off;
  logic [LW-1:0] lcnt;
  logic          start_q;
  logic [1:0]    s_phase;
  logic [1:0]    a_phase;

  assign accept = (state == ST_IDLE) && start_req && !start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      lcnt    <= '0;
      start_q <= 1'b0;
      s_phase <= '0;
      a_phase <= '0;
    end else begin
      start_q <= start_req;
      if (stage_load) s_phase <= stage_phase;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_RUN;
            cnt     <= '0;
            a_phase <= s_phase;
          end
        end
        ST_RUN: begin
          if (cnt == CW'(PERIOD_CYC - 1)) begin
            state <= ST_LOCK;
            lcnt  <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_LOCK: begin
          if (lcnt == LW'(LOCK_CYC - 1)) state <= ST_IDLE;
          else lcnt <= lcnt + LW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    clk_off   = CW'(a_phase) * CW'(STEP);
    running   = (state == ST_RUN);
    data_lvl  = running && (cnt < CW'(HALF));
    clk_lvl   = running && (cnt >= clk_off) &&
                ({1'b0, cnt} < ({1'b0, clk_off} + (CW+1)'(HALF)));
    data_rise = running && (cnt == '0);
    clk_rise  = running && (cnt == clk_off);
    data_fall = running && (cnt == CW'(HALF));
  end

  p_lock_blocks_start_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK) |=> (state != ST_RUN));

  p_run_window_r12: assert property (@(posedge clk) disable iff (rst)
    (running && cnt == CW'(PERIOD_CYC - 1)) |=> (state == ST_LOCK));

  p_clock_rise_high_r7: assert property (@(posedge clk) disable iff (rst)
    clk_rise |-> clk_lvl);

  p_single_fall_r8: assert property (@(posedge clk) disable iff (rst)
    data_fall |=> !data_fall);

endmodule

// File: rtl/tce_pin_bank.sv
module tce_pin_bank #(
  parameter int N_PINS = 139
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stage_load,
  input  logic [2*N_PINS-1:0] stage_dir,
  input  logic [N_PINS-1:0]   stage_drive,
  input  logic [2*N_PINS-1:0] stage_fmt,
  input  logic [N_PINS-1:0]   stage_wsel,
  input  logic                accept,
  input  logic                running,
  input  logic                data_lvl,
  input  logic                clk_lvl,
  input  logic                data_rise,
  input  logic                clk_rise,
  output logic [N_PINS-1:0]   drv_o,
  output logic [N_PINS-1:0]   oe_o,
  output logic [N_PINS-1:0]   out_mask
);
  import tce_pkg::*;

  // staging bank
  logic [N_PINS-1:0][1:0] s_dir, s_fmt;
  logic [N_PINS-1:0]      s_bit, s_wsel;
  // active bank
  logic [N_PINS-1:0][1:0] a_dir, a_fmt;
  logic [N_PINS-1:0]      a_bit, a_wsel;

  logic [N_PINS-1:0] nxt_drv, nxt_oe;
  logic [N_PINS-1:0] drv_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_dir  <= '0;
      s_fmt  <= '0;
      s_bit  <= '0;
      s_wsel <= '0;
      a_dir  <= '0;
      a_fmt  <= '0;
      a_bit  <= '0;
      a_wsel <= '0;
    end else begin
      if (stage_load) begin
        s_dir  <= stage_dir;
        s_fmt  <= stage_fmt;
        s_bit  <= stage_drive;
        s_wsel <= stage_wsel;
      end
      if (accept) begin
        a_dir  <= s_dir;
        a_fmt  <= s_fmt;
        a_bit  <= s_bit;
        a_wsel <= s_wsel;
      end
    end
  end

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic p_lvl, p_rise;
    assign p_lvl       = a_wsel[g] ? clk_lvl  : data_lvl;
    assign p_rise      = a_wsel[g] ? clk_rise : data_rise;
    assign nxt_drv[g]  = pin_next(a_dir[g], a_fmt[g], a_bit[g], p_lvl, p_rise, drv_q[g]);
    assign nxt_oe[g]   = (a_dir[g] == DIR_STIM);
    assign out_mask[g] = (a_dir[g] == DIR_OBS);

    p_undriven_zero_r2: assert property (@(posedge clk) disable iff (rst)
      !oe_o[g] |-> !drv_o[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= '0;
      oe_q  <= '0;
    end else begin
      drv_q <= nxt_drv;
      oe_q  <= nxt_oe;
    end
  end

  assign drv_o = drv_q;
  assign oe_o  = oe_q;

  p_active_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running)) |->
      ($stable(a_dir) && $stable(a_fmt) && $stable(a_bit) && $stable(a_wsel)));

endmodule

// File: rtl/tce_capture.sv
module tce_capture #(
  parameter int N_PINS = 139
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_fall,
  input  logic [N_PINS-1:0] out_mask,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] cap_o,
  output logic              done_o
);
  logic [N_PINS-1:0] cap_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= data_fall;
      if (data_fall) cap_q <= pin_in & out_mask;
    end
  end

  assign cap_o  = cap_q;
  assign done_o = done_q;

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_cap_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(cap_o));

endmodule

// File: rtl/tce_engine.sv
module tce_engine #(
  parameter int N_PINS     = 139,
  parameter int PERIOD_CYC = 128,
  parameter int LOCK_CYC   = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stage_load,
  input  logic [2*N_PINS-1:0] stage_dir,
  input  logic [N_PINS-1:0]   stage_drive,
  input  logic [2*N_PINS-1:0] stage_fmt,
  input  logic [N_PINS-1:0]   stage_wsel,
  input  logic [1:0]          stage_phase,
  input  logic                start_req,
  input  logic [N_PINS-1:0]   pin_in,
  output logic [N_PINS-1:0]   pin_drive,
  output logic [N_PINS-1:0]   pin_oe,
  output logic [N_PINS-1:0]   capture,
  output logic                done
);
  logic accept, running, data_lvl, clk_lvl, data_rise, clk_rise, data_fall;
  logic [N_PINS-1:0] out_mask;

  tce_timing #(.PERIOD_CYC(PERIOD_CYC), .LOCK_CYC(LOCK_CYC)) u_timing (
    .clk(clk), .rst(rst), .start_req(start_req),
    .stage_load(stage_load), .stage_phase(stage_phase),
    .accept(accept), .running(running),
    .data_lvl(data_lvl), .clk_lvl(clk_lvl),
    .data_rise(data_rise), .clk_rise(clk_rise), .data_fall(data_fall)
  );

  tce_pin_bank #(.N_PINS(N_PINS)) u_pins (
    .clk(clk), .rst(rst), .stage_load(stage_load),
    .stage_dir(stage_dir), .stage_drive(stage_drive),
    .stage_fmt(stage_fmt), .stage_wsel(stage_wsel),
    .accept(accept), .running(running),
    .data_lvl(data_lvl), .clk_lvl(clk_lvl),
    .data_rise(data_rise), .clk_rise(clk_rise),
    .drv_o(pin_drive), .oe_o(pin_oe), .out_mask(out_mask)
  );

  tce_capture #(.N_PINS(N_PINS)) u_cap (
    .clk(clk), .rst(rst), .data_fall(data_fall),
    .out_mask(out_mask), .pin_in(pin_in),
    .cap_o(capture), .done_o(done)
  );

endmodule

// File: tb/tb_tce_engine.sv
`timescale 1ns/1ps
module tb_tce_engine;
  localparam int N    = 139;
  localparam int PER  = 128;
  localparam int LOCK = 64;
  localparam int HALF = PER / 2;
  localparam int STEP = PER / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stage_load = 1'b0;
  logic [2*N-1:0] stage_dir = '0, stage_fmt = '0;
  logic [N-1:0] stage_drive = '0, stage_wsel = '0, pin_in = '0;
  logic [1:0] stage_phase = '0;
  logic start_req = 1'b0;
  logic [N-1:0] pin_drive, pin_oe, capture;
  logic done;

  tce_engine #(.N_PINS(N), .PERIOD_CYC(PER), .LOCK_CYC(LOCK)) dut (
    .clk(clk), .rst(rst), .stage_load(stage_load),
    .stage_dir(stage_dir), .stage_drive(stage_drive),
    .stage_fmt(stage_fmt), .stage_wsel(stage_wsel),
    .stage_phase(stage_phase), .start_req(start_req), .pin_in(pin_in),
    .pin_drive(pin_drive), .pin_oe(pin_oe), .capture(capture), .done(done)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [2*N-1:0] st_dir = '0, st_fmt = '0, ac_dir = '0, ac_fmt = '0;
  logic [N-1:0] st_bit = '0, st_wsel = '0, ac_bit = '0, ac_wsel = '0;
  logic [N-1:0] prev_drv = '0, exp_cap = '0;
  logic [1:0] st_phase = '0, ac_phase = '0;

  task automatic check(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Expected drive from the requirements (R2..R7, R12).
  function automatic logic [N-1:0] exp_drive(int c, bit in_run);
    logic [N-1:0] v;
    int off;
    off = int'(ac_phase) * STEP;
    for (int i = 0; i < N; i++) begin
      logic [1:0] d, f;
      logic w, lvl, armed, b;
      d = ac_dir[2*i +: 2];
      f = ac_fmt[2*i +: 2];
      w = ac_wsel[i];
      b = ac_bit[i];
      lvl   = in_run && (w ? (c >= off && c < off + HALF) : (c < HALF));
      armed = in_run && (c >= (w ? off : 0));
      if (d != 2'b01) v[i] = 1'b0;
      else if (!in_run) begin
        case (f)
          2'b00: v[i] = b;
          2'b01: v[i] = 1'b0;
          2'b10: v[i] = 1'b1;
          default: v[i] = ~b;
        endcase
      end else begin
        case (f)
          2'b00: v[i] = armed ? b : prev_drv[i];
          2'b01: v[i] = lvl ? b : 1'b0;
          2'b10: v[i] = lvl ? b : 1'b1;
          default: v[i] = armed ? ~b : prev_drv[i];
        endcase
      end
    end
    return v;
  endfunction

  function automatic logic [N-1:0] dir_mask(logic [1:0] code);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (ac_dir[2*i +: 2] == code);
    return m;
  endfunction

  function automatic string drv_tag(logic [N-1:0] diff, bit in_run);
    for (int i = 0; i < N; i++) begin
      if (diff[i]) begin
        if (ac_dir[2*i +: 2] != 2'b01) return "R2";
        if (!in_run) return "R12";
        if (ac_wsel[i]) return "R7";
        case (ac_fmt[2*i +: 2])
          2'b00: return "R3";
          2'b01: return "R4";
          2'b10: return "R5";
          default: return "R6";
        endcase
      end
    end
    return "R3";
  endfunction

  function automatic logic [N-1:0] rnd_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'($urandom % 2);
    return v;
  endfunction

  task automatic randomize_stage();
    for (int i = 0; i < N; i++) begin
      st_dir[2*i +: 2] = 2'($urandom % 4);
      st_fmt[2*i +: 2] = 2'($urandom % 4);
    end
    st_bit = rnd_vec();
    st_wsel = rnd_vec();
    st_phase = 2'($urandom % 4);
  endtask

  task automatic drive_stage();
    stage_dir = st_dir; stage_fmt = st_fmt; stage_drive = st_bit;
    stage_wsel = st_wsel; stage_phase = st_phase;
  endtask

  task automatic run_one(bit do_push, bit mid_reload, bit poke, bit hold);
    logic [N-1:0] e;
    bit in_run;
    if (do_push) begin
      @(negedge clk); drive_stage(); stage_load = 1'b1;
      @(negedge clk); stage_load = 1'b0;
    end
    @(negedge clk);
    pin_in = rnd_vec();
    start_req = 1'b1;
    prev_drv = exp_drive(0, 1'b0);
    ac_dir = st_dir; ac_fmt = st_fmt; ac_bit = st_bit;
    ac_wsel = st_wsel; ac_phase = st_phase;
    exp_cap = pin_in & dir_mask(2'b10);
    @(posedge clk);
    for (int c = 0; c < PER + LOCK; c++) begin
      @(posedge clk); #1;
      in_run = (c < PER);
      e = exp_drive(c, in_run);
      check(pin_drive === e, drv_tag(pin_drive ^ e, in_run), pin_drive, e);
      check(pin_oe === dir_mask(2'b01), "R2 oe", pin_oe, dir_mask(2'b01));
      check(done === (c == HALF), "R9 done", N'(done), N'(c == HALF));
      if (c >= HALF) check(capture === exp_cap, "R8 capture", capture, exp_cap);
      if (c == HALF + 2) pin_in = rnd_vec();
      if (mid_reload && c == 3) begin  // R10: stage during the run
        randomize_stage(); drive_stage(); stage_load = 1'b1;
      end
      if (mid_reload && c == 4) stage_load = 1'b0;
      if (poke) begin  // R11: rises inside run and lockout
        if (c == 2) start_req = 1'b0;
        if (c == 5) start_req = 1'b1;
        if (c == PER + 2) start_req = 1'b0;
        if (c == PER + 4) start_req = 1'b1;
      end else if (!hold && c == 1) start_req = 1'b0;
    end
    if (poke || hold) begin
      for (int k = 0; k < PER; k++) begin
        @(posedge clk); #1;
        e = exp_drive(0, 1'b0);
        check(done === 1'b0, "R11 no rerun", N'(done), '0);
        check(pin_drive === e, "R11 idle drive", pin_drive, e);
      end
      @(negedge clk); start_req = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd915));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(pin_drive === '0, "R1 drive", pin_drive, '0);
    check(pin_oe === '0, "R1 oe", pin_oe, '0);
    check(capture === '0, "R1 capture", capture, '0);
    check(done === 1'b0, "R1 done", N'(done), '0);

    // R3: all stimulated, non-return, data waveform
    for (int i = 0; i < N; i++) begin st_dir[2*i +: 2] = 2'b01; st_fmt[2*i +: 2] = 2'b00; end
    st_bit = rnd_vec(); st_wsel = '0; st_phase = 2'd0;
    run_one(1'b1, 1'b0, 1'b0, 1'b0);
    // R4 and R7: return-low on the clock waveform, widest phase
    for (int i = 0; i < N; i++) st_fmt[2*i +: 2] = 2'b01;
    st_bit = rnd_vec(); st_wsel = '1; st_phase = 2'd3;
    run_one(1'b1, 1'b0, 1'b0, 1'b0);
    // R8: all observed, mixed waveform selects
    for (int i = 0; i < N; i++) st_dir[2*i +: 2] = 2'b10;
    st_wsel = rnd_vec();
    run_one(1'b1, 1'b0, 1'b0, 1'b0);
    // R5 and R6: return-high and inverted mix, phase 1, start held high
    for (int i = 0; i < N; i++) begin
      st_dir[2*i +: 2] = 2'b01; st_fmt[2*i +: 2] = (i % 2 == 0) ? 2'b10 : 2'b11;
    end
    st_bit = rnd_vec(); st_wsel = rnd_vec(); st_phase = 2'd1;
    run_one(1'b1, 1'b0, 1'b0, 1'b1);
    // Constrained random runs with directed reload and start corner cases
    for (int r = 0; r < 30; r++) begin
      bit mid;
      mid = (r % 4 == 1);
      if (r % 4 != 2) randomize_stage();  // after a mid-run reload, reuse it (R10)
      run_one(r % 4 != 2, mid, r % 3 == 0, r % 5 == 4);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule